// File: doc/BRIEF.md
# Status Register and Write-Protection Gate

This block keeps the protection state of a small serial non-volatile memory and rules on every write that the serial front end decodes. It holds a write-enable latch, a protect-enable bit and a two-bit block-protect selector, and it reports these together with a live busy indication as one status byte for readback.

The front end hands it single-cycle command strobes: set or clear the latch, open a status write, commit a status write with its data byte, and request an array write at a given address. For an array write the block answers with a one-cycle permit pulse; for a status write it applies the new protection settings and raises a one-cycle update strobe. A refused request leaves the protection settings alone and drops the latch, so every write must be preceded by a fresh enable.

The active-low write-protect pin matters only once the protect-enable bit is stored as 1, and it is captured when a status write opens. Block protection guards the top quarter, the top half or the whole of the array.

Top module: `wps_status_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the latch, the protect-enable bit and the block-protect selector are 0, and the permit and update strobes are low.
- R2: A set-latch strobe makes the latch 1 on the next clock edge; a clear-latch strobe makes it 0; when both come in the same cycle the latch ends at 0.
- R3: The status byte carries busy at bit 0 (following the busy input in the same cycle), the latch at bit 1, the block-protect selector at bits 3:2 and protect-enable at bit 7; bits 6:4 always read 0.
- R4: A status write commits only when the latch is 1 and busy is low; otherwise it changes no setting and gives no update strobe.
- R5: With protect-enable at 0 the write-protect pin has no effect: a status write is accepted with the pin low.
- R6: With protect-enable at 1 a status write is refused if the pin was low in the cycle the write opened and accepted if it was high, whatever the pin does before the commit.
- R7: An array write request produces a one-cycle permit pulse on the following cycle only when the latch is 1, busy is low and the address is outside the protected range.
- R8: The block-protect selector codes are 00 nothing, 01 addresses from three quarters of the depth upward, 10 addresses from half the depth upward, 11 every address.
- R9: The latch returns to 0 after every status-write commit (accepted or not), after a refused array write, and one cycle after busy falls.
- R10: Toggling the write-protect pin while a programming cycle is busy leaves the status byte unchanged.
- R11: An accepted status write takes only data bits 7 and 3:2; every other data bit is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wren | input | 1 | Set-latch strobe |
| cmd_wrdi | input | 1 | Clear-latch strobe |
| sw_open | input | 1 | Status write recognised; samples the pin |
| sw_commit | input | 1 | Status write data complete |
| sw_data | input | 8 | Status write data byte |
| aw_req | input | 1 | Array write request strobe |
| aw_addr | input | ADDR_W | Array write address |
| prot_pin_n | input | 1 | External write-protect pin, active low |
| prog_busy | input | 1 | Programming cycle in progress |
| status_q | output | 8 | Status byte |
| arr_permit | output | 1 | One-cycle array write permission |
| stat_upd | output | 1 | One-cycle strobe when status settings change |

## Verification
Array writes are tried at addresses straddling each protection boundary (the last unprotected and first protected address for the quarter and half codes, address zero for the whole-array code), which tells apart a wrong boundary from a wrong code mapping. Status writes are tried with the pin low and high under both protect-enable values, and with the pin changing between open and commit in both directions, which separates sampling at open from sampling at commit. Writes are also issued without an enable and during busy, and the busy edge is driven with a write still outstanding, so each cause of the latch dropping is seen on its own.

// File: rtl/wps_pkg.sv
package wps_pkg;

   typedef enum logic [1:0] {
      BP_NONE    = 2'b00,
      BP_QUARTER = 2'b01,
      BP_HALF    = 2'b10,
      BP_ALL     = 2'b11
   } bp_e;

   typedef struct packed {
      logic pe;
      bp_e  bp;
   } prot_cfg_t;

   localparam int unsigned STAT_W    = 8;
   localparam int unsigned BIT_BUSY  = 0;
   localparam int unsigned BIT_WEL   = 1;
   localparam int unsigned BIT_BP_LO = 2;
   localparam int unsigned BIT_PE    = 7;

endpackage

// File: rtl/wps_wel.sv
module wps_wel (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   // clear dominates set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (clr_i) q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
   end
endmodule

// File: rtl/wps_cfg_reg.sv
module wps_cfg_reg
   import wps_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      load_i,
   input  prot_cfg_t d_i,
   output prot_cfg_t q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o <= '{pe: 1'b0, bp: BP_NONE};
      else if (load_i) q_o <= d_i;
   end
endmodule

// File: rtl/wps_region.sv
module wps_region
   import wps_pkg::*;
#(
   parameter int unsigned ADDR_W = 13
) (
   input  bp_e               bp_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o
);
   localparam int unsigned SEL_W = 2;

   generate
      if (ADDR_W < SEL_W) begin : g_bad_width
         $error("wps_region: ADDR_W must be at least 2");
      end
   endgenerate

   logic [SEL_W-1:0] top_bits;
   assign top_bits = addr_i[ADDR_W-1 -: SEL_W];

   always_comb begin
      unique case (bp_i)
         BP_NONE:    hit_o = 1'b0;
         BP_QUARTER: hit_o = &top_bits;
         BP_HALF:    hit_o = top_bits[SEL_W-1];
         default:    hit_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/wps_status_ctrl.sv
module wps_status_ctrl
   import wps_pkg::*;
#(
   parameter int unsigned ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wren,
   input  logic              cmd_wrdi,
   input  logic              sw_open,
   input  logic              sw_commit,
   input  logic [7:0]        sw_data,
   input  logic              aw_req,
   input  logic [ADDR_W-1:0] aw_addr,
   input  logic              prot_pin_n,
   input  logic              prog_busy,
   output logic [7:0]        status_q,
   output logic              arr_permit,
   output logic              stat_upd
);
   generate
      if (STAT_W != 8) begin : g_bad_stat
         $error("wps_status_ctrl: status byte must be 8 bits");
      end
   endgenerate

   logic      wel;
   logic      pin_lat;
   logic      busy_d;
   logic      hit;
   logic      sw_ok;
   logic      aw_ok;
   logic      wel_clr;
   logic      cfg_load;
   prot_cfg_t cfg;
   prot_cfg_t cfg_next;
   logic      unused_sw_bits;

   assign unused_sw_bits = ^{sw_data[6:4], sw_data[1:0]};

   wps_region #(.ADDR_W(ADDR_W)) u_region (
      .bp_i  (cfg.bp),
      .addr_i(aw_addr),
      .hit_o (hit)
   );

   // decisions
   assign sw_ok    = wel & ~prog_busy & (~cfg.pe | pin_lat);
   assign aw_ok    = wel & ~prog_busy & ~hit;
   assign cfg_load = sw_commit & sw_ok;
   assign wel_clr  = cmd_wrdi | sw_commit | (aw_req & ~aw_ok)
                   | (busy_d & ~prog_busy);

   assign cfg_next.pe = sw_data[BIT_PE];
   assign cfg_next.bp = bp_e'(sw_data[BIT_BP_LO +: 2]);

   wps_wel u_wel (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(cmd_wren),
      .clr_i(wel_clr),
      .q_o  (wel)
   );

   wps_cfg_reg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(cfg_load),
      .d_i   (cfg_next),
      .q_o   (cfg)
   );

   // busy history needs no reset: it only finds the falling edge
   always_ff @(posedge clk) begin
      busy_d <= prog_busy;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_lat    <= 1'b1;
         arr_permit <= 1'b0;
         stat_upd   <= 1'b0;
      end else begin
         if (sw_open) pin_lat <= prot_pin_n;
         arr_permit <= aw_req & aw_ok;
         stat_upd   <= cfg_load;
      end
   end

   always_comb begin
      status_q                  = '0;
      status_q[BIT_BUSY]        = prog_busy;
      status_q[BIT_WEL]         = wel;
      status_q[BIT_BP_LO +: 2]  = cfg.bp;
      status_q[BIT_PE]          = cfg.pe;
   end
endmodule

// File: rtl/wps_status_chk.sv
module wps_status_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_wrdi,
   input logic       prog_busy,
   input logic       pin_lat,
   input logic [7:0] status_q,
   input logic       arr_permit,
   input logic       stat_upd
);
   // R1: latch is clear right after any reset cycle
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> !status_q[1]);

   // R2: clear-latch strobe wins
   a_r2_wrdi_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wrdi |=> !status_q[1]);

   // R4: an update needs the latch and an idle array
   a_r4_upd_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
      stat_upd |-> ($past(status_q[1]) && !$past(prog_busy)));

   // R6: protected and pin low at open means no update
   a_r6_pin_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      stat_upd |-> !($past(status_q[7]) && !$past(pin_lat)));

   // R7: permit needs the latch and an idle array
   a_r7_permit_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
      arr_permit |-> ($past(status_q[1]) && !$past(status_q[0])));

   // R8: whole-array protection never permits
   a_r8_all_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      arr_permit |-> ($past(status_q[3:2]) != 2'b11));

   // R9: end of programming drops the latch
   a_r9_busy_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prog_busy) |=> !status_q[1]);
endmodule

bind wps_status_ctrl wps_status_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_wrdi  (cmd_wrdi),
   .prog_busy (prog_busy),
   .pin_lat   (pin_lat),
   .status_q  (status_q),
   .arr_permit(arr_permit),
   .stat_upd  (stat_upd)
);

// File: tb/test_wps_status_ctrl.sv
`timescale 1ns/1ps
module test_wps_status_ctrl;
   localparam int unsigned ADDR_W = 13;
   localparam int DEPTH = 1 << ADDR_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_wren = 1'b0, cmd_wrdi = 1'b0;
   logic              sw_open = 1'b0, sw_commit = 1'b0;
   logic [7:0]        sw_data = '0;
   logic              aw_req = 1'b0;
   logic [ADDR_W-1:0] aw_addr = '0;
   logic              prot_pin_n = 1'b1;
   logic              prog_busy = 1'b0;
   logic [7:0]        status_q;
   logic              arr_permit, stat_upd;

   int checks = 0, errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   wps_status_ctrl #(.ADDR_W(ADDR_W)) i_wps_status_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
      .sw_open(sw_open), .sw_commit(sw_commit), .sw_data(sw_data),
      .aw_req(aw_req), .aw_addr(aw_addr), .prot_pin_n(prot_pin_n),
      .prog_busy(prog_busy), .status_q(status_q),
      .arr_permit(arr_permit), .stat_upd(stat_upd)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit m_wel, m_pe, m_pin, m_perm, m_upd, m_busyd;
   int m_bp;

   function automatic bit in_prot(int bp, int a);
      case (bp)
         0: return 0;
         1: return a >= DEPTH - DEPTH / 4;
         2: return a >= DEPTH / 2;
         default: return 1;
      endcase
   endfunction

   always @(posedge clk) begin
      bit clr;
      if (!rst_n) begin
         m_wel = 0; m_pe = 0; m_bp = 0; m_pin = 1; m_perm = 0; m_upd = 0;
      end else begin
         clr = 0; m_perm = 0; m_upd = 0;
         if (sw_commit) begin
            if (m_wel && !prog_busy && (!m_pe || m_pin)) begin
               m_pe = sw_data[7]; m_bp = int'(sw_data[3:2]); m_upd = 1;
            end
            clr = 1;
         end
         if (sw_open) m_pin = prot_pin_n;
         if (aw_req) begin
            if (m_wel && !prog_busy && !in_prot(m_bp, int'(aw_addr))) m_perm = 1;
            else clr = 1;
         end
         if (m_busyd && !prog_busy) clr = 1;
         if (cmd_wrdi) clr = 1;
         if (clr) m_wel = 0;
         else if (cmd_wren) m_wel = 1;
      end
      m_busyd = prog_busy;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk(status_q, {m_pe, 3'b000, 2'(m_bp), m_wel, prog_busy}, "R3 model status");
         chk(arr_permit, m_perm, "R7 model permit");
         chk(stat_upd, m_upd, "R4 model update");
      end
   end

   task automatic tick;
      @(posedge clk); #2;
   endtask

   task automatic do_wren;
      cmd_wren = 1; tick; cmd_wren = 0;
   endtask

   task automatic do_wrdi;
      cmd_wrdi = 1; tick; cmd_wrdi = 0;
   endtask

   task automatic do_sw(input logic [7:0] d, input bit pin_open, input bit pin_commit,
                        input bit exp_upd, input string tag);
      prot_pin_n = pin_open; sw_open = 1; tick; sw_open = 0;
      prot_pin_n = pin_commit; sw_commit = 1; sw_data = d; tick;
      chk(stat_upd, exp_upd, tag);
      sw_commit = 0; prot_pin_n = 1;
   endtask

   task automatic do_aw(input int a, input bit exp, input string tag);
      aw_req = 1; aw_addr = ADDR_W'(a); tick;
      chk(arr_permit, exp, tag);
      aw_req = 0;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #1;
      chk(status_q, 8'h00, "R1 status in reset");
      chk({arr_permit, stat_upd}, 2'b00, "R1 strobes in reset");
      tick; tick;
      rst_n = 1; tick;
      chk(status_q, 8'h00, "R1 status after reset");

      // R2 latch set/clear
      do_wren; chk(status_q, 8'h02, "R2 set latch");
      do_wrdi; chk(status_q, 8'h00, "R2 clear latch");
      cmd_wren = 1; cmd_wrdi = 1; tick; cmd_wren = 0; cmd_wrdi = 0;
      chk(status_q, 8'h00, "R2 clear wins");

      // R4 no latch: refused
      do_sw(8'h8C, 1, 1, 0, "R4 no latch no update");
      chk(status_q, 8'h00, "R4 settings kept");

      // R5 protect-enable 0, pin low accepted; R9 latch drops
      do_wren; do_sw(8'h04, 0, 0, 1, "R5 pin ignored");
      chk(status_q, 8'h04, "R9 latch cleared after status write");

      // R8 quarter boundary
      do_wren; do_aw(DEPTH - DEPTH / 4, 0, "R8 quarter first protected");
      chk(status_q, 8'h04, "R9 refused write clears latch");
      do_wren; do_aw(DEPTH - DEPTH / 4 - 1, 1, "R8 quarter last free");
      chk(status_q, 8'h06, "R7 latch held while write pending");

      // R3 busy bit, R10 pin toggles during busy, R9 busy end
      prog_busy = 1; tick; chk(status_q, 8'h07, "R3 busy bit");
      prot_pin_n = 0; tick; prot_pin_n = 1; tick;
      chk(status_q, 8'h07, "R10 pin during busy");
      prog_busy = 0; tick; chk(status_q, 8'h04, "R9 busy end clears latch");

      // R7 write while busy refused
      do_wren; prog_busy = 1; tick;
      do_aw(0, 0, "R7 busy refuses write");
      chk(status_q, 8'h05, "R9 refused while busy clears latch");
      prog_busy = 0; tick;

      // R4 status write while busy refused
      do_wren; prog_busy = 1; tick;
      do_sw(8'h0C, 1, 1, 0, "R4 busy refuses status write");
      prog_busy = 0; tick;
      chk(status_q, 8'h04, "R4 settings kept after busy refusal");

      // R11 ignored bits, half protection
      do_wren; do_sw(8'hFB, 1, 1, 1, "R11 accepted");
      chk(status_q, 8'h88, "R11 only bits 7 and 3:2 taken");
      do_wren; do_aw(DEPTH / 2, 0, "R8 half first protected");
      do_wren; do_aw(DEPTH / 2 - 1, 1, "R8 half last free");
      do_wrdi;

      // R6 pin sampling at open
      do_wren; do_sw(8'h80, 0, 0, 0, "R6 pin low refused");
      chk(status_q, 8'h88, "R6 settings kept");
      do_wren; do_sw(8'h8C, 1, 0, 1, "R6 pin high at open accepted");
      chk(status_q, 8'h8C, "R6 new settings");
      do_wren; do_aw(0, 0, "R8 whole array protected");
      do_wren; do_sw(8'h00, 0, 1, 0, "R6 pin low at open refused");
      chk(status_q, 8'h8C, "R6 settings kept after late rise");

      // back to open
      do_wren; do_sw(8'h00, 1, 1, 1, "R5 clear protection");
      chk(status_q, 8'h00, "R5 cleared");
      do_wren; do_aw(DEPTH - 1, 1, "R8 no protection top address");
      do_wrdi; tick;

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule